// File: doc/BRIEF.md
# Vector Register Scalar Move Unit

This block carries 16-bit values between the scalar side of a processor and a bank of wide vector registers. A move instruction word arrives with a qualifying strobe. The unit decodes one of four moves: scalar into a vector register, vector register into scalar, scalar into a control register, and control register into scalar. Each vector register is 128 bits, seen as 16 bytes, and the move addresses it through a byte offset carried in the instruction. The offset is not a lane number. Odd offsets straddle lanes, and the last offset wraps or truncates at the end of the byte array.

Read moves return a sign-extended 32-bit result one clock after the instruction is presented. The destination register number from the instruction travels with the result, so the scalar pipeline can write it back. A write move changes storage at the clock edge that accepts it. A read presented in the very next cycle already sees the new data. The control registers are plain 16-bit storage with no side effects.

Top module: `vmv_unit`

## Requirements
- R1: An instruction is acted on only when `op_valid` is high, bits 31..26 equal 010010, and bits 25..21 hold one of four codes: 00000 (vector to scalar), 00010 (control to scalar), 00100 (scalar to vector) or 00110 (scalar to control). Any other word produces no result and changes no storage.
- R2: Bits 15..11 name the register and bits 10..7 give a byte offset. Vector byte b sits at bits 127-8b down to 120-8b, so byte 0 is the high byte of lane 0. Lane n is reached with offset 2n.
- R3: A scalar-to-vector move with offset k below 15 stores `rt_wdata[15:8]` in byte k and `rt_wdata[7:0]` in byte k+1. Every other byte of every register keeps its value.
- R4: A scalar-to-vector move with offset 15 stores only `rt_wdata[15:8]` into byte 15. Byte 0 of that register is not changed.
- R5: A vector-to-scalar move returns byte k as bits 15..8 and byte k+1 as bits 7..0. Bits 31..16 are copies of bit 15.
- R6: A vector-to-scalar move with offset 15 takes its low byte from byte 0 of the same register.
- R7: Control moves address register `vs mod NCTRL` and ignore bits 10..7. A write stores `rt_wdata[15:0]`. A read returns that value sign-extended to 32 bits.
- R8: A read move presented in cycle t gives `res_valid`, `res_data` and `res_rt` (taken from instruction bits 20..16) in cycle t+1. A write accepted in cycle t is seen by a read presented in cycle t+1.
- R9: `res_valid` is high only in the cycle after an accepted read move.
- R10: A synchronous active-high `rst` clears every vector register, every control register and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Instruction word qualifier |
| op_word | input | 32 | Move instruction word |
| rt_wdata | input | 32 | Scalar source value for write moves |
| res_valid | output | 1 | Result of a read move is present |
| res_rt | output | 5 | Scalar destination register of the result |
| res_data | output | 32 | Sign-extended read result |

## Verification
The embedded properties check several things on every cycle. A result is always properly sign-extended and only follows an accepted instruction. Reset silences the result strobe. Each vector byte that a write does not select keeps its value, which covers the offset 15 truncation. A control register not addressed by a write holds steady. A read that directly follows a write at the same register and offset returns the written half-word. The bench's behavioural byte-array model covers what the properties cannot. That includes the byte ordering within lanes, the wrap of the read at offset 15 into byte 0, odd offsets straddling lanes, the element field having no effect on control moves, and illegal words leaving storage unchanged. These become visible only through sequences of writes followed by later reads.

// File: rtl/vmv_pkg.sv
package vmv_pkg;
  localparam int VBYTES = 16;
  localparam int BYTE_W = 8;
  localparam int VEC_W  = VBYTES * BYTE_W;
  localparam int OFF_W  = 4;
  localparam int HALF_W = 16;
  localparam int REG_F  = 5;

  localparam logic [5:0] PRIMARY_OP = 6'b010010;

  typedef enum logic [4:0] {
    MV_FROM_VEC = 5'b00000,
    MV_FROM_CTL = 5'b00010,
    MV_TO_VEC   = 5'b00100,
    MV_TO_CTL   = 5'b00110
  } mv_kind_e;

  typedef struct packed {
    logic             vec_rd;
    logic             ctl_rd;
    logic             vec_wr;
    logic             ctl_wr;
    logic [REG_F-1:0] vs;
    logic [REG_F-1:0] rt;
    logic [OFF_W-1:0] off;
  } mv_dec_t;

  function automatic logic [31:0] sext_half(input logic [HALF_W-1:0] h);
    return {{(32-HALF_W){h[HALF_W-1]}}, h};
  endfunction
endpackage

// File: rtl/vmv_decode.sv
module vmv_decode
  import vmv_pkg::*;
(
  input  logic        valid,
  input  logic [31:7] word,
  output mv_dec_t     dec
);
  logic hit;
  logic [4:0] kind;

  assign hit  = valid && (word[31:26] == PRIMARY_OP);
  assign kind = word[25:21];

  always_comb begin
    dec        = '0;
    dec.rt     = word[20:16];
    dec.vs     = word[15:11];
    dec.off    = word[10:7];
    if (hit) begin
      unique case (kind)
        MV_FROM_VEC: dec.vec_rd = 1'b1;
        MV_FROM_CTL: dec.ctl_rd = 1'b1;
        MV_TO_VEC:   dec.vec_wr = 1'b1;
        MV_TO_CTL:   dec.ctl_wr = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/vmv_vbank.sv
module vmv_vbank
  import vmv_pkg::*;
#(
  parameter int VREG_N = 32,
  localparam int IDX_W = $clog2(VREG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [HALF_W-1:0] wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [HALF_W-1:0] rd_val
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(VBYTES - 1);

  logic [BYTE_W-1:0] row_byte [VBYTES];
  logic [VBYTES-1:0] be;

  for (genvar b = 0; b < VBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] lane_mem [VREG_N];
    logic [BYTE_W-1:0] wbyte;
    logic              is_hi;
    logic              is_lo;

    assign is_hi = (wr_off == OFF_W'(b));
    assign is_lo = (wr_off != LAST_OFF) && ((wr_off + OFF_W'(1)) == OFF_W'(b));
    assign be[b] = we && (is_hi || is_lo);
    assign wbyte = is_hi ? wr_val[HALF_W-1 -: BYTE_W] : wr_val[BYTE_W-1:0];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < VREG_N; i++) lane_mem[i] <= '0;
      end else if (be[b]) begin
        lane_mem[wr_idx] <= wbyte;
      end
    end

    assign row_byte[b] = lane_mem[rd_idx];

    // checker state: a byte not enabled by a write must keep its value
    logic              chk_arm_q;
    logic [IDX_W-1:0]  chk_idx_q;
    logic [BYTE_W-1:0] chk_old_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chk_arm_q <= 1'b0;
        chk_idx_q <= '0;
        chk_old_q <= '0;
      end else begin
        chk_arm_q <= we && !be[b];
        chk_idx_q <= wr_idx;
        chk_old_q <= lane_mem[wr_idx];
      end
    end

    p_untouched_byte_r4: assert property (@(posedge clk) disable iff (rst)
      chk_arm_q |-> (lane_mem[chk_idx_q] == chk_old_q))
      else $error("unselected vector byte changed by write");
  end

  // offset+1 wraps naturally in OFF_W bits, giving byte 0 after byte 15
  assign rd_val = {row_byte[rd_off], row_byte[rd_off + OFF_W'(1)]};

  p_two_bytes_max_r3: assert property (@(posedge clk) disable iff (rst)
    we |-> ($countones(be) == ((wr_off == LAST_OFF) ? 1 : 2)))
    else $error("write enabled a wrong number of bytes");
endmodule

// File: rtl/vmv_cbank.sv
module vmv_cbank
  import vmv_pkg::*;
#(
  parameter int NCTRL = 4,
  localparam int CI_W = (NCTRL > 1) ? $clog2(NCTRL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CI_W-1:0]   idx,
  input  logic [HALF_W-1:0] wr_val,
  output logic [HALF_W-1:0] rd_val
);
  logic [HALF_W-1:0] regs [NCTRL];

  for (genvar i = 0; i < NCTRL; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)                            regs[i] <= '0;
      else if (we && idx == CI_W'(i))     regs[i] <= wr_val;
    end

    p_ctl_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(we && idx == CI_W'(i)) |=> $stable(regs[i]))
      else $error("unaddressed control register changed");
  end

  assign rd_val = regs[idx];
endmodule

// File: rtl/vmv_unit.sv
module vmv_unit
  import vmv_pkg::*;
#(
  parameter int VREG_N = 32,
  parameter int NCTRL  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_valid,
  input  logic [31:0] op_word,
  input  logic [31:0] rt_wdata,
  output logic        res_valid,
  output logic [4:0]  res_rt,
  output logic [31:0] res_data
);
  localparam int IDX_W = $clog2(VREG_N);
  localparam int CI_W  = (NCTRL > 1) ? $clog2(NCTRL) : 1;

  logic unused_bits;
  assign unused_bits = ^{op_word[6:0], rt_wdata[31:16]};

  mv_dec_t           dec;
  logic [HALF_W-1:0] vec_rd;
  logic [HALF_W-1:0] ctl_rd;

  vmv_decode u_dec (
    .valid (op_valid),
    .word  (op_word[31:7]),
    .dec   (dec)
  );

  vmv_vbank #(.VREG_N(VREG_N)) u_vbank (
    .clk    (clk),
    .rst    (rst),
    .we     (dec.vec_wr),
    .wr_idx (dec.vs[IDX_W-1:0]),
    .wr_off (dec.off),
    .wr_val (rt_wdata[HALF_W-1:0]),
    .rd_idx (dec.vs[IDX_W-1:0]),
    .rd_off (dec.off),
    .rd_val (vec_rd)
  );

  vmv_cbank #(.NCTRL(NCTRL)) u_cbank (
    .clk    (clk),
    .rst    (rst),
    .we     (dec.ctl_wr),
    .idx    (dec.vs[CI_W-1:0]),
    .wr_val (rt_wdata[HALF_W-1:0]),
    .rd_val (ctl_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_rt    <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= dec.vec_rd || dec.ctl_rd;
      if (dec.vec_rd || dec.ctl_rd) begin
        res_rt   <= dec.rt;
        res_data <= sext_half(dec.vec_rd ? vec_rd : ctl_rd);
      end
    end
  end

  // checker state: last accepted vector write
  logic              pw_v;
  logic [REG_F-1:0]  pw_vs;
  logic [OFF_W-1:0]  pw_off;
  logic [HALF_W-1:0] pw_val;
  always_ff @(posedge clk) begin
    if (rst) begin
      pw_v   <= 1'b0;
      pw_vs  <= '0;
      pw_off <= '0;
      pw_val <= '0;
    end else begin
      pw_v   <= dec.vec_wr;
      pw_vs  <= dec.vs;
      pw_off <= dec.off;
      pw_val <= rt_wdata[HALF_W-1:0];
    end
  end

  p_raw_r8: assert property (@(posedge clk) disable iff (rst)
    (pw_v && dec.vec_rd && dec.vs == pw_vs && dec.off == pw_off && pw_off != OFF_W'(VBYTES - 1))
      |=> (res_data[HALF_W-1:0] == $past(pw_val)))
    else $error("read after write returned stale data");

  p_sext_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_data[31:HALF_W] == {(32-HALF_W){res_data[HALF_W-1]}}))
    else $error("result not sign extended");

  p_valid_src_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(op_valid))
    else $error("result without instruction");

  p_quiet_r10: assert property (@(posedge clk)
    rst |=> !res_valid)
    else $error("result strobe after reset");
endmodule

// File: tb/tb_vmv_unit.sv
module tb_vmv_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [31:0] op_word;
  logic [31:0] rt_wdata;
  logic        res_valid;
  logic [4:0]  res_rt;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  vm [32][16];
  logic [15:0] cm [4];

  always #2 clk = ~clk;

  vmv_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .rt_wdata(rt_wdata), .res_valid(res_valid), .res_rt(res_rt), .res_data(res_data)
  );

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] rt,
                                     input logic [4:0] vs, input logic [3:0] el);
    return {6'b010010, op, rt, vs, el, 7'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 32; r++)
      for (int b = 0; b < 16; b++) vm[r][b] = 8'h00;
    for (int c = 0; c < 4; c++) cm[c] = 16'h0000;
  endtask

  // one instruction per cycle; model computes the expected registered result
  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] r, input string tag);
    logic        ev;
    logic [31:0] ed;
    logic [4:0]  ert;
    logic [3:0]  off;
    logic [4:0]  vs;
    ev = 1'b0; ed = '0; ert = w[20:16]; off = w[10:7]; vs = w[15:11];
    if (v && w[31:26] == 6'b010010) begin
      case (w[25:21])
        5'b00000: begin ev = 1'b1;
          ed = {{16{vm[vs][off][7]}}, vm[vs][off], vm[vs][4'(off + 4'd1)]}; end
        5'b00010: begin ev = 1'b1; ed = {{16{cm[vs % 4][15]}}, cm[vs % 4]}; end
        5'b00100: begin vm[vs][off] = r[15:8];
          if (off != 4'd15) vm[vs][off + 4'd1] = r[7:0]; end
        5'b00110: cm[vs % 4] = r[15:0];
        default: ;
      endcase
    end
    op_valid = v; op_word = w; rt_wdata = r;
    @(posedge clk); #1;
    chk({tag, " R9 valid"}, {31'b0, res_valid}, {31'b0, ev});
    if (ev) begin
      chk({tag, " R8 rt"}, {27'b0, res_rt}, {27'b0, ert});
      chk({tag, " data"}, res_data, ed);
    end
    @(negedge clk);
  endtask

  task automatic vwr(input logic [4:0] vs, input logic [3:0] el, input logic [15:0] d, input string t);
    step(1'b1, mk(5'b00100, 5'd0, vs, el), {16'hdead, d}, t);
  endtask
  task automatic vrd(input logic [4:0] vs, input logic [3:0] el, input string t);
    step(1'b1, mk(5'b00000, 5'd7, vs, el), 32'h0, t);
  endtask

  task automatic do_reset();
    rst = 1'b1; op_valid = 1'b0; op_word = '0; rt_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 res_valid in reset", {31'b0, res_valid}, 32'd0);
    @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10: storage reads zero after reset
    vrd(5'd0, 4'd0, "R10");
    vrd(5'd31, 4'd14, "R10");
    step(1'b1, mk(5'b00010, 5'd3, 5'd2, 4'd0), 0, "R10 ctl");

    // R2/R3/R5: lane writes, readback including straddling offset
    vwr(5'd4, 4'd8, 16'h1234, "R2");
    vrd(5'd4, 4'd8, "R2 R8 raw");
    vrd(5'd4, 4'd7, "R2 straddle");
    vrd(5'd4, 4'd9, "R2 straddle");
    vwr(5'd4, 4'd3, 16'habcd, "R3");
    vrd(5'd4, 4'd2, "R3");
    vrd(5'd4, 4'd4, "R3");
    vrd(5'd4, 4'd8, "R3 neighbour");
    vrd(5'd5, 4'd3, "R3 other reg");
    vwr(5'd9, 4'd0, 16'h8001, "R5");
    vrd(5'd9, 4'd0, "R5 negative");

    // R4/R6: offset 15 truncation and wrap
    vwr(5'd6, 4'd0, 16'h5a5a, "R4");
    vwr(5'd6, 4'd15, 16'hc3ff, "R4");
    vrd(5'd6, 4'd0, "R4 byte0 kept");
    vrd(5'd6, 4'd14, "R4");
    vrd(5'd6, 4'd15, "R6 wrap");

    // R7: control moves, element ignored, index wraps
    step(1'b1, mk(5'b00110, 5'd0, 5'd1, 4'd9), 32'h0000_9abc, "R7 wr");
    step(1'b1, mk(5'b00010, 5'd12, 5'd1, 4'd3), 0, "R7 rd");
    step(1'b1, mk(5'b00010, 5'd12, 5'd5, 4'd15), 0, "R7 alias");
    step(1'b1, mk(5'b00110, 5'd0, 5'd3, 4'd15), 32'h0000_7fff, "R7 wr");
    step(1'b1, mk(5'b00010, 5'd1, 5'd3, 4'd0), 0, "R7 rd");
    vrd(5'd1, 4'd3, "R7 vec untouched");

    // R1: illegal words and unqualified words change nothing
    step(1'b1, {6'b010011, 5'b00100, 5'd0, 5'd4, 4'd8, 7'd0}, 32'h0000_ffff, "R1 primary");
    step(1'b1, mk(5'b00101, 5'd0, 5'd4, 4'd8), 32'h0000_ffff, "R1 kind");
    step(1'b0, mk(5'b00100, 5'd0, 5'd4, 4'd8), 32'h0000_ffff, "R1 invalid");
    step(1'b0, mk(5'b00000, 5'd0, 5'd4, 4'd8), 0, "R1 no read");
    vrd(5'd4, 4'd8, "R1 unchanged");
    step(1'b1, mk(5'b01000, 5'd0, 5'd1, 4'd0), 32'h0000_1111, "R1 kind");
    step(1'b1, mk(5'b00010, 5'd2, 5'd1, 4'd0), 0, "R1 ctl unchanged");

    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [4:0] k;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: k = 5'b00000;
        3:       k = 5'b00010;
        4, 5, 6: k = 5'b00100;
        7:       k = 5'b00110;
        8:       k = 5'b00001;
        default: k = 5'b00000;
      endcase
      step($urandom_range(0, 7) != 0,
           mk(k, 5'($urandom), 5'($urandom_range(0, 7)), 4'($urandom)),
           $urandom, "R3 R5 R6 random");
    end

    // R10: reset mid-run clears storage
    vwr(5'd2, 4'd0, 16'hffff, "R10 pre");
    do_reset();
    vrd(5'd2, 4'd0, "R10 cleared");
    vrd(5'd6, 4'd15, "R10 cleared");
    step(1'b1, mk(5'b00010, 5'd0, 5'd3, 4'd0), 0, "R10 ctl cleared");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule